// File: doc/BRIEF.md
# Configurable Energy Accumulator Engine

The engine turns a stream of per-sample power values (active, reactive and apparent) into energy totals. Each valid sample is first shaped by an accumulation mode, then passed through a no-load gate that keeps low-level noise from being integrated. Finally it is summed into an internal per-channel accumulator. The accumulators are closed out at the end of a window. A window is measured either in input samples or in half line cycles, the latter marked by a zero-crossing strobe from an upstream detector.

When a window closes, each user-visible energy register is updated, either by adding the window total to it or by replacing it with that total. The internal accumulator restarts from zero, and an energy-ready pulse tells the host that fresh values are available. A read port selects one user register. Optionally, a read clears the register it selects. All totals saturate at the signed limits of the register width.

Top module: `egy_accum_top`

## Requirements
- R1: Active and reactive power each have their own 2-bit mode select: 0 passes the signed sample, 1 takes its magnitude, 2 keeps positive samples and maps negative ones to 0, 3 keeps negative samples and maps positive ones to 0. Apparent power is always summed as given (signed).
- R2: With `win_base_i`=0 the window counts sample strobes, and with 1 it counts `zx_i` strobes. The window closes on the `win_len_i`-th counted event, where 0 behaves as 1. A sample presented in the closing cycle belongs to the closing window.
- R3: At window close, `overwrite_i`=0 adds the window total to each user register and `overwrite_i`=1 replaces it. The internal accumulator restarts at zero for the next window.
- R4: `egy_rdy_o` is high for exactly one cycle, the cycle after a window closes. The new user values appear in that same cycle. Apart from a clear, user registers change at no other time.
- R5: `rd_data_o` shows the register chosen by `rd_sel_i` (0 active, 1 reactive, 2 apparent). With `rd_clr_en_i`=1, a cycle with `rd_i` high returns the old value and zeroes that register on the next edge. With `rd_clr_en_i`=0, the register is left unchanged.
- R6: If a clearing read and a window close hit the same register in the same cycle, the register ends up holding only the closing window's total.
- R7: Each channel has a magnitude level and a shared timer count. Once a channel's sample magnitude has stayed below its level for the timer count of consecutive samples, the channel enters no-load (`*_nl_o`=1) and its samples are not accumulated, starting with the sample that completes the count. The first sample at or above the level leaves no-load and is accumulated.
- R8: While `egy_en_i`=0 nothing is accumulated, the window count does not advance and `egy_rdy_o` stays low.
- R9: Internal and user totals saturate at the most positive and most negative values of the `EGY_W`-bit register instead of wrapping.
- R10: After reset all user registers, `egy_rdy_o` and all no-load flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_vld_i | input | 1 | Power sample strobe |
| act_pwr_i | input | PWR_W | Active power sample, signed |
| react_pwr_i | input | PWR_W | Reactive power sample, signed |
| app_pwr_i | input | PWR_W | Apparent power sample, signed |
| zx_i | input | 1 | Half line cycle strobe |
| egy_en_i | input | 1 | Global energy enable |
| act_mode_i | input | 2 | Active accumulation mode |
| react_mode_i | input | 2 | Reactive accumulation mode |
| win_base_i | input | 1 | Window base: 0 samples, 1 half cycles |
| win_len_i | input | WIN_W | Window length in events |
| overwrite_i | input | 1 | 0 add to user register, 1 overwrite |
| rd_clr_en_i | input | 1 | Clear user register on read |
| act_nl_lvl_i | input | PWR_W | Active no-load magnitude level |
| react_nl_lvl_i | input | PWR_W | Reactive no-load magnitude level |
| app_nl_lvl_i | input | PWR_W | Apparent no-load magnitude level |
| nl_tmr_i | input | TMR_W | No-load timer count in samples |
| rd_i | input | 1 | Read strobe |
| rd_sel_i | input | 2 | Read select |
| rd_data_o | output | EGY_W | Selected user register |
| act_egy_o | output | EGY_W | Active energy user register |
| react_egy_o | output | EGY_W | Reactive energy user register |
| app_egy_o | output | EGY_W | Apparent energy user register |
| egy_rdy_o | output | 1 | Energy-ready pulse |
| act_nl_o | output | 1 | Active no-load state |
| react_nl_o | output | 1 | Reactive no-load state |
| app_nl_o | output | 1 | Apparent no-load state |

## Verification
The bench builds the engine with 16-bit samples, 20-bit energy registers, an 8-bit window length and a 4-bit no-load timer. With these widths, seventeen full-scale samples drive the user registers past both signed limits, so saturation in each direction is reached in a few dozen cycles rather than millions. A short timer count likewise makes entry into and exit from no-load visible within a five-sample sequence. The small window length lets sample-based and half-cycle-based windows, and the collision between a window close and a clearing read, be exercised directly.

// File: rtl/egy_pkg.sv
package egy_pkg;
  typedef enum logic [1:0] {
    ACC_SIGNED = 2'd0,
    ACC_ABS    = 2'd1,
    ACC_POS    = 2'd2,
    ACC_NEG    = 2'd3
  } acc_mode_e;

  localparam int NUM_CH   = 3;
  localparam int CH_ACT   = 0;
  localparam int CH_REACT = 1;
  localparam int CH_APP   = 2;
endpackage

// File: rtl/egy_mode_sel.sv
module egy_mode_sel #(
  parameter int PWR_W = 24
) (
  input  logic signed [PWR_W-1:0] pwr_i,
  input  logic        [1:0]       mode_i,
  output logic signed [PWR_W:0]   pwr_o
);
  import egy_pkg::*;

  logic signed [PWR_W:0] ext;
  logic                  neg;
  logic                  nz;

  assign ext = {pwr_i[PWR_W-1], pwr_i};
  assign neg = ext[PWR_W];
  assign nz  = (ext != '0);

  always_comb begin
    unique case (acc_mode_e'(mode_i))
      ACC_SIGNED: pwr_o = ext;
      ACC_ABS:    pwr_o = neg ? -ext : ext;
      ACC_POS:    pwr_o = (!neg && nz) ? ext : '0;
      ACC_NEG:    pwr_o = neg ? ext : '0;
      default:    pwr_o = ext;
    endcase
  end
endmodule

// File: rtl/egy_noload.sv
module egy_noload #(
  parameter int PWR_W = 24,
  parameter int TMR_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sample_i,
  input  logic signed [PWR_W-1:0] pwr_i,
  input  logic        [PWR_W-1:0] lvl_i,
  input  logic        [TMR_W-1:0] tmr_i,
  output logic                    drop_o,
  output logic                    nl_o
);
  logic signed [PWR_W:0] ext;
  logic        [PWR_W:0] mag;
  logic                  below;
  logic [TMR_W-1:0]      cnt_q, cnt_inc;
  logic                  reached;

  assign ext     = {pwr_i[PWR_W-1], pwr_i};
  assign mag     = ext[PWR_W] ? -ext : ext;
  assign below   = mag < {1'b0, lvl_i};
  assign cnt_inc = (&cnt_q) ? cnt_q : cnt_q + 1'b1;
  assign reached = (cnt_inc >= tmr_i);
  assign drop_o  = sample_i && below && reached;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      nl_o  <= 1'b0;
    end else if (sample_i) begin
      cnt_q <= below ? cnt_inc : '0;
      nl_o  <= below && reached;
    end
  end
endmodule

// File: rtl/egy_window.sv
module egy_window #(
  parameter int WIN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             base_i,
  input  logic             sample_i,
  input  logic             zx_i,
  input  logic [WIN_W-1:0] len_i,
  output logic             end_o
);
  logic [WIN_W-1:0] cnt_q;
  logic [WIN_W:0]   cnt_inc;
  logic             evt;

  assign evt     = en_i && (base_i ? zx_i : sample_i);
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  // len 0 compares true on every event, so it behaves as 1
  assign end_o   = evt && (cnt_inc >= {1'b0, len_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (end_o)  cnt_q <= '0;
    else if (evt)    cnt_q <= cnt_inc[WIN_W-1:0];
  end
endmodule

// File: rtl/egy_chan.sv
module egy_chan #(
  parameter int PWR_W = 24,
  parameter int EGY_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    add_i,
  input  logic signed [PWR_W:0]   pwr_i,
  input  logic                    end_i,
  input  logic                    overwrite_i,
  input  logic                    clr_i,
  output logic signed [EGY_W-1:0] egy_o
);
  localparam int EXT_W = EGY_W - PWR_W - 1;

  logic signed [EGY_W-1:0] acc_q, contrib, sum_sat, tot_sat;
  logic        [EGY_W:0]   sum_w, tot_w;

  function automatic logic signed [EGY_W-1:0] sat(input logic [EGY_W:0] v);
    if (v[EGY_W] != v[EGY_W-1])
      sat = v[EGY_W] ? {1'b1, {(EGY_W-1){1'b0}}} : {1'b0, {(EGY_W-1){1'b1}}};
    else
      sat = v[EGY_W-1:0];
  endfunction

  assign contrib = add_i ? {{EXT_W{pwr_i[PWR_W]}}, pwr_i} : '0;
  assign sum_w   = {acc_q[EGY_W-1], acc_q} + {contrib[EGY_W-1], contrib};
  assign sum_sat = sat(sum_w);
  assign tot_w   = {egy_o[EGY_W-1], egy_o} + {sum_sat[EGY_W-1], sum_sat};
  assign tot_sat = sat(tot_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      egy_o <= '0;
    end else begin
      acc_q <= end_i ? '0 : sum_sat;
      if (end_i)     egy_o <= (overwrite_i || clr_i) ? sum_sat : tot_sat;
      else if (clr_i) egy_o <= '0;
    end
  end
endmodule

// File: rtl/egy_accum_top.sv
module egy_accum_top #(
  parameter int PWR_W = 24,
  parameter int EGY_W = 32,
  parameter int WIN_W = 16,
  parameter int TMR_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sample_vld_i,
  input  logic signed [PWR_W-1:0] act_pwr_i,
  input  logic signed [PWR_W-1:0] react_pwr_i,
  input  logic signed [PWR_W-1:0] app_pwr_i,
  input  logic                    zx_i,
  input  logic                    egy_en_i,
  input  logic [1:0]              act_mode_i,
  input  logic [1:0]              react_mode_i,
  input  logic                    win_base_i,
  input  logic [WIN_W-1:0]        win_len_i,
  input  logic                    overwrite_i,
  input  logic                    rd_clr_en_i,
  input  logic [PWR_W-1:0]        act_nl_lvl_i,
  input  logic [PWR_W-1:0]        react_nl_lvl_i,
  input  logic [PWR_W-1:0]        app_nl_lvl_i,
  input  logic [TMR_W-1:0]        nl_tmr_i,
  input  logic                    rd_i,
  input  logic [1:0]              rd_sel_i,
  output logic signed [EGY_W-1:0] rd_data_o,
  output logic signed [EGY_W-1:0] act_egy_o,
  output logic signed [EGY_W-1:0] react_egy_o,
  output logic signed [EGY_W-1:0] app_egy_o,
  output logic                    egy_rdy_o,
  output logic                    act_nl_o,
  output logic                    react_nl_o,
  output logic                    app_nl_o
);
  import egy_pkg::*;

  logic signed [PWR_W-1:0] pwr_a  [NUM_CH];
  logic        [PWR_W-1:0] lvl_a  [NUM_CH];
  logic        [1:0]       mode_a [NUM_CH];
  logic signed [EGY_W-1:0] egy_a  [NUM_CH];
  logic        [NUM_CH-1:0] nl_a;
  logic                    win_end;

  assign pwr_a[CH_ACT]   = act_pwr_i;
  assign pwr_a[CH_REACT] = react_pwr_i;
  assign pwr_a[CH_APP]   = app_pwr_i;
  assign lvl_a[CH_ACT]   = act_nl_lvl_i;
  assign lvl_a[CH_REACT] = react_nl_lvl_i;
  assign lvl_a[CH_APP]   = app_nl_lvl_i;
  assign mode_a[CH_ACT]   = act_mode_i;
  assign mode_a[CH_REACT] = react_mode_i;
  assign mode_a[CH_APP]   = ACC_SIGNED;

  egy_window #(.WIN_W(WIN_W)) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (egy_en_i),
    .base_i   (win_base_i),
    .sample_i (sample_vld_i),
    .zx_i     (zx_i),
    .len_i    (win_len_i),
    .end_o    (win_end)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic signed [PWR_W:0] shaped;
    logic                  drop;
    logic                  clr;

    assign clr = rd_i && rd_clr_en_i && (rd_sel_i == 2'(g));

    egy_mode_sel #(.PWR_W(PWR_W)) u_mode (
      .pwr_i  (pwr_a[g]),
      .mode_i (mode_a[g]),
      .pwr_o  (shaped)
    );

    egy_noload #(.PWR_W(PWR_W), .TMR_W(TMR_W)) u_nl (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sample_i (sample_vld_i),
      .pwr_i    (pwr_a[g]),
      .lvl_i    (lvl_a[g]),
      .tmr_i    (nl_tmr_i),
      .drop_o   (drop),
      .nl_o     (nl_a[g])
    );

    egy_chan #(.PWR_W(PWR_W), .EGY_W(EGY_W)) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .add_i       (sample_vld_i && egy_en_i && !drop),
      .pwr_i       (shaped),
      .end_i       (win_end),
      .overwrite_i (overwrite_i),
      .clr_i       (clr),
      .egy_o       (egy_a[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) egy_rdy_o <= 1'b0;
    else         egy_rdy_o <= win_end;
  end

  always_comb begin
    unique case (rd_sel_i)
      2'd0:    rd_data_o = egy_a[CH_ACT];
      2'd1:    rd_data_o = egy_a[CH_REACT];
      2'd2:    rd_data_o = egy_a[CH_APP];
      default: rd_data_o = '0;
    endcase
  end

  assign act_egy_o   = egy_a[CH_ACT];
  assign react_egy_o = egy_a[CH_REACT];
  assign app_egy_o   = egy_a[CH_APP];
  assign act_nl_o    = nl_a[CH_ACT];
  assign react_nl_o  = nl_a[CH_REACT];
  assign app_nl_o    = nl_a[CH_APP];
endmodule

// File: rtl/egy_accum_chk.sv
module egy_accum_chk #(
  parameter int PWR_W = 24,
  parameter int EGY_W = 32
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    sample_vld_i,
  input logic signed [PWR_W-1:0] act_pwr_i,
  input logic [PWR_W-1:0]        act_nl_lvl_i,
  input logic                    zx_i,
  input logic                    egy_en_i,
  input logic                    win_base_i,
  input logic                    rd_clr_en_i,
  input logic                    rd_i,
  input logic [1:0]              rd_sel_i,
  input logic signed [EGY_W-1:0] act_egy_o,
  input logic signed [EGY_W-1:0] react_egy_o,
  input logic signed [EGY_W-1:0] app_egy_o,
  input logic                    egy_rdy_o,
  input logic                    act_nl_o
);
  logic [PWR_W:0] act_mag;
  assign act_mag = act_pwr_i[PWR_W-1] ? (PWR_W+1)'(-{act_pwr_i[PWR_W-1], act_pwr_i})
                                      : {1'b0, act_pwr_i};

  p_off_no_rdy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !egy_en_i |=> !egy_rdy_o);

  p_zx_base_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_base_i && !zx_i) |=> !egy_rdy_o);

  p_clear_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && rd_clr_en_i && rd_sel_i == 2'd0) |=> (act_egy_o == '0 || egy_rdy_o));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && rd_clr_en_i) |=>
      (egy_rdy_o || ($stable(act_egy_o) && $stable(react_egy_o) && $stable(app_egy_o))));

  p_nl_exit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_vld_i && act_mag >= {1'b0, act_nl_lvl_i}) |=> !act_nl_o);
endmodule

bind egy_accum_top egy_accum_chk #(.PWR_W(PWR_W), .EGY_W(EGY_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sample_vld_i (sample_vld_i),
  .act_pwr_i    (act_pwr_i),
  .act_nl_lvl_i (act_nl_lvl_i),
  .zx_i         (zx_i),
  .egy_en_i     (egy_en_i),
  .win_base_i   (win_base_i),
  .rd_clr_en_i  (rd_clr_en_i),
  .rd_i         (rd_i),
  .rd_sel_i     (rd_sel_i),
  .act_egy_o    (act_egy_o),
  .react_egy_o  (react_egy_o),
  .app_egy_o    (app_egy_o),
  .egy_rdy_o    (egy_rdy_o),
  .act_nl_o     (act_nl_o)
);

// File: tb/sim_egy_accum_top.sv
module sim_egy_accum_top;
  localparam int PW = 16;
  localparam int EW = 20;
  localparam int WW = 8;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_vld = 1'b0, zx = 1'b0, egy_en = 1'b0;
  logic signed [PW-1:0] act_p = '0, react_p = '0, app_p = '0;
  logic [1:0] act_mode = '0, react_mode = '0;
  logic win_base = 1'b0, overwrite = 1'b1, rd_clr_en = 1'b0, rd = 1'b0;
  logic [WW-1:0] win_len = 8'd1;
  logic [PW-1:0] act_lvl = '0, react_lvl = '0, app_lvl = '0;
  logic [TW-1:0] nl_tmr = 4'd3;
  logic [1:0] rd_sel = '0;
  logic signed [EW-1:0] rd_data, act_e, react_e, app_e;
  logic rdy, act_nl, react_nl, app_nl;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  egy_accum_top #(.PWR_W(PW), .EGY_W(EW), .WIN_W(WW), .TMR_W(TW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sample_vld_i(sample_vld),
    .act_pwr_i(act_p), .react_pwr_i(react_p), .app_pwr_i(app_p),
    .zx_i(zx), .egy_en_i(egy_en), .act_mode_i(act_mode), .react_mode_i(react_mode),
    .win_base_i(win_base), .win_len_i(win_len), .overwrite_i(overwrite),
    .rd_clr_en_i(rd_clr_en), .act_nl_lvl_i(act_lvl), .react_nl_lvl_i(react_lvl),
    .app_nl_lvl_i(app_lvl), .nl_tmr_i(nl_tmr), .rd_i(rd), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data), .act_egy_o(act_e), .react_egy_o(react_e), .app_egy_o(app_e),
    .egy_rdy_o(rdy), .act_nl_o(act_nl), .react_nl_o(react_nl), .app_nl_o(app_nl)
  );

  // act mode, act power, act expected, react mode, react power, react expected, app power
  localparam int NV = 8;
  localparam int T_AM [NV] = '{0, 1, 2, 3, 0, 1, 2, 1};
  localparam int T_AP [NV] = '{-5, -5, -5, -5, 7, 7, 7, -32768};
  localparam int T_EA [NV] = '{-5, 5, 0, -5, 7, 7, 7, 32768};
  localparam int T_RM [NV] = '{1, 0, 3, 2, 3, 2, 1, 3};
  localparam int T_RP [NV] = '{-9, -9, -9, -9, 9, 9, -32768, 4};
  localparam int T_ER [NV] = '{9, -9, -9, 0, 0, 9, 32768, 0};
  localparam int T_PP [NV] = '{100, -3, 0, 250, -1, 32767, -32768, 11};

  task automatic chk(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic smp(input int a, input int r, input int ap, input logic z);
    @(negedge clk);
    act_p = PW'(a); react_p = PW'(r); app_p = PW'(ap);
    zx = z; sample_vld = 1'b1;
    @(negedge clk);
    sample_vld = 1'b0; zx = 1'b0;
  endtask

  task automatic rd_reg(input int sel, input logic clr, output longint v);
    @(negedge clk);
    rd = 1'b1; rd_sel = 2'(sel); rd_clr_en = clr;
    #1 v = longint'(rd_data);
    @(negedge clk);
    rd = 1'b0; rd_clr_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    longint v;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 act", act_e, 0);
    chk("R10 react", react_e, 0);
    chk("R10 app", app_e, 0);
    chk("R10 rdy", rdy, 0);
    chk("R10 nl", {act_nl, react_nl, app_nl}, 0);
    rst_n = 1'b1;

    // R8 disabled: nothing moves
    smp(10, 10, 10, 1'b0);
    chk("R8 rdy", rdy, 0);
    chk("R8 act", act_e, 0);
    chk("R8 app", app_e, 0);
    egy_en = 1'b1;

    // R1 mode table: one-sample windows, overwrite
    for (int i = 0; i < NV; i++) begin
      act_mode = 2'(T_AM[i]);
      react_mode = 2'(T_RM[i]);
      smp(T_AP[i], T_RP[i], T_PP[i], 1'b0);
      chk("R1 act", act_e, T_EA[i]);
      chk("R1 react", react_e, T_ER[i]);
      chk("R1 app", app_e, T_PP[i]);
      chk("R4 rdy", rdy, 1);
    end
    act_mode = 2'd0; react_mode = 2'd0;

    // R5 read without and with clear
    rd_reg(0, 1'b0, v);
    chk("R5 read data", v, 32768);
    chk("R5 no clear", act_e, 32768);
    rd_reg(0, 1'b1, v);
    chk("R5 clear data", v, 32768);
    chk("R5 cleared", act_e, 0);
    rd_reg(1, 1'b1, v);
    rd_reg(2, 1'b1, v);
    chk("R5 app cleared", app_e, 0);

    // R3 add mode, 3-sample window (R2)
    overwrite = 1'b0; win_len = 8'd3;
    smp(10, 1, 2, 1'b0);
    chk("R2 mid rdy", rdy, 0);
    chk("R4 mid hold", act_e, 0);
    smp(20, 1, 2, 1'b0);
    chk("R2 mid2 hold", act_e, 0);
    smp(30, 1, 2, 1'b0);
    chk("R2 close rdy", rdy, 1);
    chk("R3 act", act_e, 60);
    chk("R3 react", react_e, 3);
    chk("R3 app", app_e, 6);
    @(negedge clk);
    chk("R4 pulse ends", rdy, 0);
    smp(5, 0, 0, 1'b0); smp(5, 0, 0, 1'b0); smp(5, 0, 0, 1'b0);
    chk("R3 add", act_e, 75);

    // R3 overwrite
    overwrite = 1'b1;
    smp(1, 0, 0, 1'b0); smp(2, 0, 0, 1'b0); smp(3, 0, 0, 1'b0);
    chk("R3 overwrite", act_e, 6);

    // R2 half-cycle base, two half cycles
    win_base = 1'b1; win_len = 8'd2;
    smp(4, 0, 0, 1'b0);
    smp(4, 0, 0, 1'b1);
    chk("R2 zx mid rdy", rdy, 0);
    chk("R2 zx mid hold", act_e, 6);
    smp(4, 0, 0, 1'b0);
    smp(4, 0, 0, 1'b1);
    chk("R2 zx close rdy", rdy, 1);
    chk("R2 zx total", act_e, 16);

    // R6 clear and close in the same cycle
    win_base = 1'b0; win_len = 8'd1; overwrite = 1'b0;
    @(negedge clk);
    act_p = 16'sd7; react_p = '0; app_p = '0; sample_vld = 1'b1;
    rd = 1'b1; rd_sel = 2'd0; rd_clr_en = 1'b1;
    @(negedge clk);
    sample_vld = 1'b0; rd = 1'b0; rd_clr_en = 1'b0;
    chk("R6 priority", act_e, 7);
    chk("R6 rdy", rdy, 1);

    // R9 saturation both directions
    rd_reg(0, 1'b1, v);
    rd_reg(1, 1'b1, v);
    for (int i = 0; i < 16; i++) smp(32767, -32768, 0, 1'b0);
    chk("R9 below max", act_e, 524272);
    chk("R9 at min", react_e, -524288);
    smp(32767, -32768, 0, 1'b0);
    chk("R9 sat max", act_e, 524287);
    chk("R9 sat min", react_e, -524288);

    // R7 no-load: level 100, timer 3
    rd_reg(0, 1'b1, v);
    rd_reg(1, 1'b1, v);
    act_lvl = 16'd100; nl_tmr = 4'd3;
    smp(50, 0, 0, 1'b0);
    chk("R7 s1", act_e, 50);
    smp(50, 0, 0, 1'b0);
    chk("R7 s2", act_e, 100);
    chk("R7 nl s2", act_nl, 0);
    smp(50, 0, 0, 1'b0);
    chk("R7 s3 dropped", act_e, 100);
    chk("R7 nl s3", act_nl, 1);
    smp(50, 0, 0, 1'b0);
    chk("R7 s4 dropped", act_e, 100);
    smp(200, 0, 0, 1'b0);
    chk("R7 exit adds", act_e, 300);
    chk("R7 nl exit", act_nl, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule